// File: doc/BRIEF.md
# Sub-Second Prescaler with Atomic Time Shift

This block keeps the fractional part of a timekeeping clock. A down-counter, the sub-second count, is stepped once per enable pulse from a preceding coarse divider. When the count leaves zero it reloads from a programmable reload value, and the block reports one elapsed second to the calendar logic that follows.

Software can move the time by a fraction of a second in one atomic step. A shift request carries a fraction and an optional whole-second flag. The fraction is added to the down-counter, which delays the clock by fraction/(reload+1) seconds. Setting the whole-second flag as well turns the net effect into an advance of 1 − fraction/(reload+1) seconds.

While a shift is waiting, a pending flag is raised and further requests are dropped. A shadow-synchronized flag goes low when a request is taken. It comes back once the shadow copy downstream holds the shifted time.

Top module: `subsec_shift_unit`

## Requirements
- R1: After reset, subSec is 0, secStep is 0, shiftPend is 0 and shadowSync is 0.
- R2: On a clock edge with ckEn high and no shift to apply, a non-zero subSec decrements by one and secStep is 0 in the next cycle. A zero subSec reloads from reloadVal and secStep is 1. With ckEn low, subSec holds and secStep is 0.
- R3: A shiftWr taken while shiftPend is 0 is accepted. In the next cycle shiftPend is 1 and shadowSync is 0. subSec is not touched by the acceptance itself.
- R4: A shiftWr while shiftPend is 1 is ignored. Its fraction and whole-second flag have no effect on any later count or secStep.
- R5: The first ckEn edge after acceptance applies the shift. subSec becomes the normal next count plus the fraction. If that sum exceeds reloadVal, reloadVal+1 is subtracted and no extra second is reported for this wrap. shiftPend returns to 0. Fractions are expected to be at most reloadVal.
- R6: On the apply edge, secStep (2 bits, a count of seconds) equals the normal reload second (0 or 1) plus 1 if the whole-second flag was set. Both can occur together, which gives 2, so no intermediate time is ever visible.
- R7: shadowSync rises at the second ckEn edge after the apply edge, or after reset, provided that no new request is accepted in between.
- R8: A request accepted on the same edge as a ckEn pulse lets that pulse make a normal step. The shift waits for the following ckEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ckEn | input | 1 | Step enable from the coarse divider |
| reloadVal | input | 15 | Reload value of the sub-second counter |
| shiftWr | input | 1 | Shift request strobe |
| shiftAddSec | input | 1 | Request adds one whole second |
| shiftFrac | input | 15 | Fraction added to the counter |
| subSec | output | 15 | Current sub-second count |
| secStep | output | 2 | Seconds elapsed on the last edge (0 to 2) |
| shiftPend | output | 1 | A shift is waiting to be applied |
| shadowSync | output | 1 | Shadow copy reflects the current time |

## Verification
With a reload value of 7, the bench sweeps every starting count against every fraction, with and without the whole-second flag. This covers the apply edge that coincides with the counter leaving zero. A design that skipped the decrement on the apply edge would land one count high. A design that reported a second for the modular wrap, or that split a double second over two cycles, would show the wrong secStep. Requests sent during a pending shift and requests that coincide with ckEn are also driven. Here a leaky guard would apply the second fraction, and a premature apply would shift a pulse too early. The shadowSync edge is timed against the second enable pulse, to catch an off-by-one wait.

// File: rtl/subsec_pkg.sv
package subsec_pkg;

  typedef struct packed {
    logic capture;
    logic step;
    logic apply;
    logic addSec;
  } ctrlStrobes_t;

endpackage

// File: rtl/subsec_ctrl.sv
module subsec_ctrl
  import subsec_pkg::*;
#(
  parameter int SYNC_STEPS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ckEn,
  input  logic         shiftWr,
  input  logic         shiftAddSec,
  output ctrlStrobes_t stb,
  output logic         shiftPend,
  output logic         shadowSync
);

  localparam int SC_W = (SYNC_STEPS > 1) ? $clog2(SYNC_STEPS) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SYNC_STEPS - 1);

  logic            accept;
  logic            applyNow;
  logic            addQ;
  logic            syncBusy;
  logic [SC_W-1:0] syncCnt;

  assign accept   = shiftWr & ~shiftPend;
  assign applyNow = ckEn & shiftPend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftPend <= 1'b0;
      addQ      <= 1'b0;
    end else if (accept) begin
      shiftPend <= 1'b1;
      addQ      <= shiftAddSec;
    end else if (applyNow) begin
      shiftPend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadowSync <= 1'b0;
      syncBusy   <= 1'b1;
      syncCnt    <= '0;
    end else if (accept) begin
      shadowSync <= 1'b0;
      syncBusy   <= 1'b0;
      syncCnt    <= '0;
    end else if (applyNow) begin
      syncBusy   <= 1'b1;
      syncCnt    <= '0;
    end else if (syncBusy && ckEn) begin
      if (syncCnt == SC_LAST) begin
        shadowSync <= 1'b1;
        syncBusy   <= 1'b0;
      end else begin
        syncCnt <= syncCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.capture = accept;
    stb.step    = ckEn;
    stb.apply   = applyNow;
    stb.addSec  = addQ;
  end

  // R4: a pending shift stays pending until an enable pulse
  a_r4_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (shiftPend && !ckEn) |=> shiftPend);

  // R3: acceptance raises pending and drops the sync flag
  a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (shiftWr && !shiftPend) |=> (shiftPend && !shadowSync));

  // R5: the apply edge clears pending
  a_r5_clear_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (shiftPend && ckEn) |=> !shiftPend);

  // R7: the sync flag rises only on an enable edge
  a_r7_rise_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shadowSync) |-> $past(ckEn));

endmodule

// File: rtl/subsec_dp.sv
module subsec_dp
  import subsec_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     stb,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] shiftFrac,
  output logic [CNT_W-1:0] subSec,
  output logic [1:0]       secStep
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] fracQ;
  logic             isZero;
  logic [CNT_W-1:0] baseNext;
  logic [SUM_W-1:0] sumW;
  logic [SUM_W-1:0] modulus;
  logic [SUM_W-1:0] adjW;
  logic [1:0]       stepSecs;

  always_comb begin
    isZero   = (count == '0);
    baseNext = isZero ? reloadVal : count - 1'b1;
    sumW     = {1'b0, baseNext} + {1'b0, fracQ};
    modulus  = {1'b0, reloadVal} + SUM_W'(1);
    if (sumW > {1'b0, reloadVal}) adjW = sumW - modulus;
    else                          adjW = sumW;
    stepSecs = {1'b0, isZero} + {1'b0, stb.apply & stb.addSec};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fracQ <= '0;
    else if (stb.capture) fracQ <= shiftFrac;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      secStep <= 2'd0;
    end else if (stb.step) begin
      count   <= stb.apply ? adjW[CNT_W-1:0] : baseNext;
      secStep <= stepSecs;
    end else begin
      secStep <= 2'd0;
    end
  end

  assign subSec = count;

  // R2: no enable, no movement and no second
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.step |=> ($stable(count) && secStep == 2'd0));

  // R2: plain step from a non-zero count decrements
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.step && !stb.apply && count != '0) |=> (count == $past(count) - 1'b1));

  // R6: two seconds at once only on an apply edge
  a_r6_double_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (secStep == 2'd2) |-> $past(stb.apply));

endmodule

// File: rtl/subsec_shift_unit.sv
module subsec_shift_unit
  import subsec_pkg::*;
#(
  parameter int CNT_W      = 15,
  parameter int SYNC_STEPS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ckEn,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             shiftWr,
  input  logic             shiftAddSec,
  input  logic [CNT_W-1:0] shiftFrac,
  output logic [CNT_W-1:0] subSec,
  output logic [1:0]       secStep,
  output logic             shiftPend,
  output logic             shadowSync
);

  ctrlStrobes_t stb;

  subsec_ctrl #(.SYNC_STEPS(SYNC_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ckEn(ckEn), .shiftWr(shiftWr),
    .shiftAddSec(shiftAddSec), .stb(stb), .shiftPend(shiftPend),
    .shadowSync(shadowSync)
  );

  subsec_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reloadVal(reloadVal),
    .shiftFrac(shiftFrac), .subSec(subSec), .secStep(secStep)
  );

endmodule

// File: tb/subsec_shift_unit_tb.sv
module subsec_shift_unit_tb;

  localparam int W = 15;
  localparam int P = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ckEn = 1'b0;
  logic [W-1:0] reloadVal = W'(P);
  logic         shiftWr = 1'b0;
  logic         shiftAddSec = 1'b0;
  logic [W-1:0] shiftFrac = '0;
  logic [W-1:0] subSec;
  logic [1:0]   secStep;
  logic         shiftPend;
  logic         shadowSync;

  int checks = 0;
  int errors = 0;

  // expected-state model
  int mCount = 0, mStep = 0, mFrac = 0, mCnt = 0;
  bit mPend = 0, mAdd = 0, mSync = 0, mBusy = 1;

  always #5 clk = ~clk;

  subsec_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ckEn(ckEn), .reloadVal(reloadVal),
    .shiftWr(shiftWr), .shiftAddSec(shiftAddSec), .shiftFrac(shiftFrac),
    .subSec(subSec), .secStep(secStep), .shiftPend(shiftPend),
    .shadowSync(shadowSync)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    chk(tag, "subSec", int'(subSec), mCount);
    chk(tag, "secStep", int'(secStep), mStep);
    chk(tag, "shiftPend", int'(shiftPend), int'(mPend));
    chk(tag, "shadowSync", int'(shadowSync), int'(mSync));
  endtask

  task automatic cyc(input bit ck, input bit wr, input bit add, input int fr, input string tag);
    bit acc;
    bit app;
    int base;
    bit wrap;
    @(negedge clk);
    ckEn = ck; shiftWr = wr; shiftAddSec = add; shiftFrac = W'(fr);
    @(posedge clk);
    #1;
    acc = wr && !mPend;
    app = ck && mPend;
    if (ck) begin
      wrap = (mCount == 0);
      base = wrap ? P : mCount - 1;
      if (app) begin
        base = base + mFrac;
        if (base > P) base = base - (P + 1);
      end
      mCount = base;
      mStep  = int'(wrap) + ((app && mAdd) ? 1 : 0);
    end else begin
      mStep = 0;
    end
    if (acc) begin
      mSync = 0; mBusy = 0; mCnt = 0;
    end else if (app) begin
      mBusy = 1; mCnt = 0;
    end else if (mBusy && ck) begin
      if (mCnt == 1) begin mSync = 1; mBusy = 0; end
      else mCnt++;
    end
    if (acc) begin mPend = 1; mFrac = fr; mAdd = add; end
    else if (app) mPend = 0;
    chkAll(tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chkAll("R1");

    // R2 and R7: free counting, sync after reset
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R2");

    // R5 R6 sweep: every start count x every fraction x whole-second flag
    for (int st = 0; st <= P; st++) begin
      for (int fr = 0; fr <= P; fr++) begin
        for (int ad = 0; ad < 2; ad++) begin
          while (mCount != st) cyc(1, 0, 0, 0, "R2");
          cyc(0, 1, ad[0], fr, "R3");
          cyc(0, 0, 0, 0, "R3");
          cyc(1, 0, 0, 0, "R5_R6");
          cyc(0, 0, 0, 0, "R7");
          cyc(1, 0, 0, 0, "R7");
          cyc(0, 0, 0, 0, "R7");
          cyc(1, 0, 0, 0, "R7");
          cyc(0, 0, 0, 0, "R7");
        end
      end
    end

    // R4: later requests during pending are dropped
    cyc(0, 1, 0, 1, "R3");
    cyc(0, 1, 1, 5, "R4");
    cyc(0, 1, 1, 6, "R4");
    cyc(1, 1, 1, 3, "R4");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, "R4");

    // R8: request on the same edge as an enable pulse
    cyc(1, 1, 1, 4, "R8");
    cyc(1, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, "R7");
    // accept interrupts a running sync wait
    cyc(1, 1, 0, 2, "R8");
    cyc(1, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, "R7");
    cyc(1, 1, 0, 0, "R7");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule